// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast oscillator-side clock by an integer N that may differ from one output cycle to the next. N is built from three parts. The first is a 9-bit main count M. The second is a 4-bit swallow count A. The third is a prescaler whose base ratio P is either 5 (stretching to 6) or 10 (stretching to 11). During each output cycle the main counter counts M+1 prescaler cycles, and the first A of those are stretched by one input clock. A small signed correction from a fractional modulator is added to N for one cycle at a time, so the average ratio can take values between integers.

In bypass mode the prescaler and the swallow counter stay idle, and the main counter divides the input clock directly. The programmed values take effect only at the end of an output cycle. A separate hold input instead reloads the counters on every clock until it is released. There are two outputs: a one-clock pulse that marks the end of every output cycle, and the prescaler's stretch request.

Top module: `pswal_divider`

## Requirements
- R1: With `smallModSel` low and `bypassPre` low, consecutive `fp` pulses are N = 10·(M+1) + A + F input clocks apart. M is `mainDiv` (1 to 511), A is `swallowCnt` and F is `fracOfs`, all as sampled at the start of that output cycle.
- R2: With `smallModSel` high and `bypassPre` low, the spacing is N = 5·(M+1) + A + F.
- R3: Outside bypass, `modSel` is high for exactly (A+F)·(P+1) input clocks of each output cycle, where P is 5 or 10. Those clocks are the first A+F prescaler cycles. A+F must stay within 0 to M+1.
- R4: With `bypassPre` high, the spacing is M + 1 + F. `modSel` stays low and `swallowCnt` has no effect.
- R5: `fracOfs` is a 4-bit two's-complement value in the range −3 to +4. It is sampled once per output cycle and affects only the cycle that follows that sample.
- R6: `mainDiv`, `swallowCnt`, `smallModSel`, `bypassPre` and `fracOfs` are sampled only on the clock edge that ends an output cycle. Changing them at any other time leaves the current interval unchanged.
- R7: `fp` is high for exactly one input clock, the last clock of each output cycle.
- R8: While `forceLoad` is high, the counters reload from the inputs on every clock and `fp` stays low. The first `fp` comes N clocks after the last edge at which `forceLoad` was high, with N taken from the inputs at that edge.
- R9: A synchronous active-high `rst` clears all counters and holds `fp` and `modSel` low. The first edge with `rst` low loads the inputs, so the first `fp` arrives N clocks after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-side input clock |
| rst | input | 1 | Synchronous reset, active high |
| mainDiv | input | 9 | Main count M |
| swallowCnt | input | 4 | Swallow count A |
| fracOfs | input | 4 | Signed per-cycle offset F |
| smallModSel | input | 1 | High selects the 5/6 prescaler, low selects 10/11 |
| bypassPre | input | 1 | High bypasses the prescaler |
| forceLoad | input | 1 | Continuous immediate reload |
| fp | output | 1 | One-clock pulse at each terminal count |
| modSel | output | 1 | Prescaler stretch request |

## Verification
The assertions take it that every input set sampled at a load edge is legal. That means M is at least 1 and F lies between −3 and +4. Outside bypass A+F must lie between 0 and M+1, and in bypass M+F must be at least 1, so every cycle is at least two clocks long. The bench chooses each offset from a rotating value and then clamps it into these windows for the M and A of that cycle. It changes inputs in the middle of a cycle only to other legal sets.

// File: rtl/pswal_pkg.sv
package pswal_pkg;
  localparam int unsigned MAIN_W_DEF    = 9;
  localparam int unsigned SWAL_W_DEF    = 4;
  localparam int unsigned OFS_W_DEF     = 4;
  localparam int unsigned PRE_SMALL_DEF = 5;
  localparam int unsigned PRE_LARGE_DEF = 10;

  // strobes from the control half to the prescaler datapath
  typedef struct packed {
    logic restart;   // counters reload on this edge
    logic stretch;   // current prescaler cycle is one clock longer
    logic bypass;    // prescaler idle, every input clock is a tick
    logic smallMod;  // 5/6 instead of 10/11
  } preStrobe_t;
endpackage

// File: rtl/pswal_prescaler.sv
module pswal_prescaler
  import pswal_pkg::*;
#(
  parameter int unsigned PRE_SMALL = PRE_SMALL_DEF,
  parameter int unsigned PRE_LARGE = PRE_LARGE_DEF
) (
  input  logic       clk,
  input  logic       rst,
  input  preStrobe_t strb,
  output logic       preTick
);
  localparam int unsigned CW = $clog2(PRE_LARGE + 1);
  localparam logic [CW-1:0] SMALL_LAST = CW'(PRE_SMALL - 1);
  localparam logic [CW-1:0] LARGE_LAST = CW'(PRE_LARGE - 1);

  logic [CW-1:0] preCnt;
  logic [CW-1:0] lastIdx;

  always_comb begin
    lastIdx = (strb.smallMod ? SMALL_LAST : LARGE_LAST) + {{(CW-1){1'b0}}, strb.stretch};
    preTick = strb.bypass | (preCnt == lastIdx);
  end

  always_ff @(posedge clk) begin
    if (rst || strb.restart || strb.bypass) preCnt <= '0;
    else if (preTick)                        preCnt <= '0;
    else                                     preCnt <= preCnt + 1'b1;
  end

  // R1: the prescaler count never runs past the end of its current cycle
  a_r1_pre_bound: assert property (@(posedge clk) disable iff (rst)
    preCnt <= lastIdx);

  // R4: in bypass the prescaler stays parked at zero
  a_r4_bypass_idle: assert property (@(posedge clk) disable iff (rst)
    strb.bypass |=> preCnt == '0);
endmodule

// File: rtl/pswal_datapath.sv
module pswal_datapath
  import pswal_pkg::*;
#(
  parameter int unsigned MAIN_W    = MAIN_W_DEF,
  parameter int unsigned SWAL_W    = SWAL_W_DEF,
  parameter int unsigned OFS_W     = OFS_W_DEF,
  parameter int unsigned PRE_SMALL = PRE_SMALL_DEF,
  parameter int unsigned PRE_LARGE = PRE_LARGE_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [MAIN_W-1:0]       mainDiv,
  input  logic [SWAL_W-1:0]       swallowCnt,
  input  logic signed [OFS_W-1:0] fracOfs,
  input  logic                    bypassIn,
  input  preStrobe_t              strb,
  output logic [MAIN_W:0]         mainLoad,
  output logic [SWAL_W:0]         swalLoad,
  output logic                    preTick
);
  localparam int unsigned MLW = MAIN_W + 1;
  localparam int unsigned SLW = SWAL_W + 1;

  int mSum;
  int aSum;

  // offset lands on the main count in bypass, on the swallow count otherwise
  always_comb begin
    mSum     = int'(mainDiv) + (bypassIn ? int'(fracOfs) : 0);
    aSum     = bypassIn ? 0 : int'(swallowCnt) + int'(fracOfs);
    mainLoad = MLW'(mSum);
    swalLoad = SLW'(aSum);
  end

  pswal_prescaler #(.PRE_SMALL(PRE_SMALL), .PRE_LARGE(PRE_LARGE)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .preTick(preTick)
  );

  // R5: offset stays inside its legal window whenever it is sampled
  a_r5_ofs_range: assert property (@(posedge clk) disable iff (rst)
    strb.restart |-> (int'(fracOfs) >= -3 && int'(fracOfs) <= 4));

  // R3: swallow count with offset fits inside the main count
  a_r3_swallow_legal: assert property (@(posedge clk) disable iff (rst)
    (strb.restart && !bypassIn) |-> (aSum >= 0 && aSum <= int'(mainDiv) + 1));

  // R4: bypass division stays at two clocks or more
  a_r4_bypass_min: assert property (@(posedge clk) disable iff (rst)
    (strb.restart && bypassIn) |-> mSum >= 1);

  // R1: main count is never loaded as zero
  a_r1_main_min: assert property (@(posedge clk) disable iff (rst)
    strb.restart |-> mainDiv != '0);
endmodule

// File: rtl/pswal_control.sv
module pswal_control
  import pswal_pkg::*;
#(
  parameter int unsigned MAIN_W = MAIN_W_DEF,
  parameter int unsigned SWAL_W = SWAL_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              forceLoad,
  input  logic              smallModIn,
  input  logic              bypassIn,
  input  logic [MAIN_W:0]   mainLoad,
  input  logic [SWAL_W:0]   swalLoad,
  input  logic              preTick,
  output preStrobe_t        strb,
  output logic              fp,
  output logic              modSel
);
  logic [MAIN_W:0] mainCnt;
  logic [SWAL_W:0] swCnt;
  logic            startPending;
  logic            smallReg;
  logic            bypReg;
  logic            termCnt;
  logic            loadNow;

  always_comb begin
    termCnt      = preTick && (mainCnt == '0) && !startPending;
    loadNow      = termCnt || startPending || forceLoad;
    strb.restart = loadNow;
    strb.stretch = (swCnt != '0);
    strb.bypass  = bypReg;
    strb.smallMod = smallReg;
    fp           = termCnt;
    modSel       = (swCnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mainCnt      <= '0;
      swCnt        <= '0;
      startPending <= 1'b1;
      smallReg     <= 1'b0;
      bypReg       <= 1'b0;
    end else if (loadNow) begin
      mainCnt      <= mainLoad;
      swCnt        <= swalLoad;
      smallReg     <= smallModIn;
      bypReg       <= bypassIn;
      startPending <= 1'b0;
    end else if (preTick) begin
      mainCnt <= mainCnt - 1'b1;
      if (swCnt != '0) swCnt <= swCnt - 1'b1;
    end
  end

  // R7: the output pulse is one clock wide
  a_r7_fp_one_wide: assert property (@(posedge clk) disable iff (rst)
    fp |=> !fp);

  // R8: no pulse while reload is held
  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    forceLoad |=> !fp);

  // R9: first cycle out of reset is quiet on both outputs
  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fp && !modSel));

  // R3: remaining stretched cycles never outnumber remaining main cycles
  a_r3_swallow_fits: assert property (@(posedge clk) disable iff (rst)
    (!startPending && !bypReg) |-> int'(swCnt) <= int'(mainCnt) + 1);

  // R4: no stretch request in bypass
  a_r4_no_stretch: assert property (@(posedge clk) disable iff (rst)
    (bypReg && !startPending) |-> !modSel);
endmodule

// File: rtl/pswal_divider.sv
module pswal_divider
  import pswal_pkg::*;
#(
  parameter int unsigned MAIN_W    = MAIN_W_DEF,
  parameter int unsigned SWAL_W    = SWAL_W_DEF,
  parameter int unsigned OFS_W     = OFS_W_DEF,
  parameter int unsigned PRE_SMALL = PRE_SMALL_DEF,
  parameter int unsigned PRE_LARGE = PRE_LARGE_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [MAIN_W-1:0]       mainDiv,
  input  logic [SWAL_W-1:0]       swallowCnt,
  input  logic signed [OFS_W-1:0] fracOfs,
  input  logic                    smallModSel,
  input  logic                    bypassPre,
  input  logic                    forceLoad,
  output logic                    fp,
  output logic                    modSel
);
  preStrobe_t      strb;
  logic [MAIN_W:0] mainLoad;
  logic [SWAL_W:0] swalLoad;
  logic            preTick;

  pswal_datapath #(
    .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .OFS_W(OFS_W),
    .PRE_SMALL(PRE_SMALL), .PRE_LARGE(PRE_LARGE)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .mainDiv   (mainDiv),
    .swallowCnt(swallowCnt),
    .fracOfs   (fracOfs),
    .bypassIn  (bypassPre),
    .strb      (strb),
    .mainLoad  (mainLoad),
    .swalLoad  (swalLoad),
    .preTick   (preTick)
  );

  pswal_control #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .forceLoad (forceLoad),
    .smallModIn(smallModSel),
    .bypassIn  (bypassPre),
    .mainLoad  (mainLoad),
    .swalLoad  (swalLoad),
    .preTick   (preTick),
    .strb      (strb),
    .fp        (fp),
    .modSel    (modSel)
  );
endmodule

// File: tb/pswal_divider_test.sv
module pswal_divider_test;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [8:0]        mainDiv = '0;
  logic [3:0]        swallowCnt = '0;
  logic signed [3:0] fracOfs = '0;
  logic              smallModSel = 1'b0;
  logic              bypassPre = 1'b0;
  logic              forceLoad = 1'b0;
  logic              fp;
  logic              modSel;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int cnt, hi, expN, expHi;
  string tagN;

  always #10 clk = ~clk;

  pswal_divider uut (
    .clk(clk), .rst(rst), .mainDiv(mainDiv), .swallowCnt(swallowCnt),
    .fracOfs(fracOfs), .smallModSel(smallModSel), .bypassPre(bypassPre),
    .forceLoad(forceLoad), .fp(fp), .modSel(modSel)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pickOff(input int m, input int a, input int byp, input int k);
    int o = (k % 8) - 3;
    if (byp != 0) begin
      if (m + o < 1) o = 1 - m;
    end else begin
      if (a + o < 0) o = -a;
      if (a + o > m + 1) o = m + 1 - a;
    end
    return o;
  endfunction

  task automatic setCfg(input int m, input int a, input int sel, input int byp, input int off);
    int p = (sel != 0) ? 5 : 10;
    mainDiv     = m[8:0];
    swallowCnt  = a[3:0];
    fracOfs     = off[3:0];
    smallModSel = (sel != 0);
    bypassPre   = (byp != 0);
    expN  = (byp != 0) ? m + 1 + off : p * (m + 1) + a + off;
    expHi = (byp != 0) ? 0 : (a + off) * (p + 1);
    tagN  = (byp != 0) ? "R4" : ((sel != 0) ? "R2" : "R1");
    tagN  = $sformatf("%s/R5 M=%0d A=%0d F=%0d", tagN, m, a, off);
  endtask

  // counts clocks until fp; checks interval (R7) and stretch time (R3)
  task automatic endCycle(input int c0, input int h0, input bit scramble);
    string t = scramble ? {tagN, " R6"} : tagN;
    cnt = c0;
    hi  = h0;
    while (1) begin
      @(negedge clk);
      cnt++;
      hi += modSel ? 1 : 0;
      if (fp) break;
      if (scramble && cnt == 2) begin
        mainDiv = 9'd7; swallowCnt = 4'd3; fracOfs = 4'sd2;
        smallModSel = ~smallModSel; bypassPre = ~bypassPre;
      end
    end
    check(cnt == expN, {"R7 interval ", t}, cnt, expN);
    check(hi == expHi, {"R3 stretch clocks ", t}, hi, expHi);
  endtask

  initial begin
    int k = 0;
    setCfg(3, 2, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(fp == 1'b0, "R9 fp in reset", int'(fp), 0);
    check(modSel == 1'b0, "R9 modSel in reset", int'(modSel), 0);
    rst = 1'b0;
    endCycle(0, 0, 1'b0);

    // sweep: 10/11, 5/6, bypass over small M and every legal A
    for (int mode = 0; mode < 3; mode++) begin
      for (int m = 1; m <= 12; m++) begin
        for (int a = 0; a <= ((m + 1 < 15) ? m + 1 : 15); a++) begin
          int byp = (mode == 2) ? 1 : 0;
          setCfg(m, a, (mode == 1) ? 1 : 0, byp, pickOff(m, a, byp, k));
          endCycle(0, 0, (k % 3) == 1);
          k++;
        end
      end
    end

    // R5: every offset on a fixed configuration, offset changing each cycle
    for (int mode = 0; mode < 3; mode++) begin
      for (int off = -3; off <= 4; off++) begin
        setCfg((mode == 2) ? 4 : 6, 3, (mode == 1) ? 1 : 0, (mode == 2) ? 1 : 0, off);
        endCycle(0, 0, 1'b0);
      end
    end

    // range edges: largest M, A = M+1, smallest bypass ratio, A ignored in bypass
    setCfg(511, 15, 0, 0, 4);  endCycle(0, 0, 1'b0);
    setCfg(511, 15, 1, 0, -3); endCycle(0, 0, 1'b0);
    setCfg(511, 0, 0, 1, 4);   endCycle(0, 0, 1'b0);
    setCfg(1, 2, 0, 0, 0);     endCycle(0, 0, 1'b0);
    setCfg(1, 2, 1, 0, 0);     endCycle(0, 0, 1'b0);
    setCfg(1, 15, 0, 1, 0);    endCycle(0, 0, 1'b0);
    setCfg(1, 0, 0, 1, 0);     endCycle(0, 0, 1'b0);
    setCfg(1, 0, 0, 1, 0);     endCycle(0, 0, 1'b0);

    // R8: held reload, values changed while held
    setCfg(9, 4, 0, 0, 1);
    forceLoad = 1'b1;
    @(negedge clk); check(fp == 1'b0, "R8 fp while held", int'(fp), 0);
    setCfg(5, 2, 1, 0, -1);
    @(negedge clk); check(fp == 1'b0, "R8 fp while held", int'(fp), 0);
    @(negedge clk); check(fp == 1'b0, "R8 fp while held", int'(fp), 0);
    @(negedge clk); check(fp == 1'b0, "R8 fp while held", int'(fp), 0);
    forceLoad = 1'b0;
    endCycle(1, modSel ? 1 : 0, 1'b0);
    setCfg(2, 1, 0, 0, 0); endCycle(0, 0, 1'b0);

    // R9: reset in the middle of a cycle
    repeat (3) @(negedge clk);
    rst = 1'b1;
    setCfg(4, 1, 1, 0, 2);
    @(negedge clk);
    @(negedge clk);
    check(fp == 1'b0, "R9 fp after mid reset", int'(fp), 0);
    check(modSel == 1'b0, "R9 modSel after mid reset", int'(modSel), 0);
    rst = 1'b0;
    endCycle(0, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule